// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block takes a freshly powered SD card from its native state into SPI mode and sets it up for single-block transfers. It owns the card chip-select and a byte-exchange port toward an SPI master. On that port one request moves one byte out and brings one byte back in the same transfer. On a start request it sends the power-up idle clocks and the software-reset command. It then polls the card with the leave-idle command until the card reports ready, switches the serial clock to the faster operating rate, and programs a 512-byte block length. The outcome is a one-cycle completion pulse or a sticky failure flag.

Each command goes out as a six-byte frame, followed by a fixed window of eight fill bytes during which the card's answer is collected. Both polling stages use a bounded retry budget with a fixed pause between tries. The pause is counted in clock cycles from a cycles-per-millisecond parameter, so a simulation can shorten it. Once bring-up has succeeded, later start requests are answered at once and leave the bus untouched.

Top module: `sdi_init_seq`

## Requirements
- R1: After a start request on an uninitialized card, the first PRE_BYTES (default 10) transfers carry 0xFF with `cs_n` high.
- R2: Every command is sent as the command byte, the 32-bit argument most significant byte first, then 0x95, followed by POLL_BYTES (default 8) transfers of 0xFF. `cs_n` is low for all of these transfers and high outside of them.
- R3: A command's response is the last byte received during its poll window that differs from 0xFF, or 0xFF when every polled byte was 0xFF.
- R4: The reset command (byte 0x40, argument 0) is repeated until its response is 0x01, for at most MAX_TRIES (default 100) attempts. When all attempts fail, `err` rises in the cycle after the last byte of the last attempt, no `done` pulse is given, and the bus goes quiet.
- R5: After a failed attempt that is not the last, no transfer is requested for at least WAIT_MS*CYC_PER_MS cycles before the retry starts.
- R6: After the reset stage, the idle-exit command (byte 0x41, argument 0) is repeated until its response is 0x00, with the same retry budget, pause and failure behaviour as R4 and R5.
- R7: `fast_rate` is 0 from reset and from every start request that begins a bring-up. It becomes 1 in the cycle after the last byte of the successful idle-exit attempt, before any byte of the block-length command.
- R8: After the idle-exit stage the block-length command (byte 0x50, argument 0x00000200) is sent once and its response is not examined. In the cycle after its last poll byte, `done` is high for exactly one cycle and `err` stays low.
- R9: Once bring-up has succeeded, a start request produces `done` in the next cycle and no transfer, until the next reset.
- R10: `err` stays high until a start request is sampled, and is low from the cycle after that request. A start request made while a bring-up is in progress has no effect.
- R11: While `xfer_req` is high and `xfer_ack` is low, `xfer_req` stays high and `xfer_tx` keeps its value. A transfer completes on a cycle in which `xfer_req` and `xfer_ack` are both high, and `xfer_rx` is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request a bring-up; one cycle is enough |
| xfer_req | output | 1 | A byte transfer is requested |
| xfer_tx | output | 8 | Byte to send in the current transfer |
| xfer_ack | input | 1 | Transfer complete in this cycle |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |
| cs_n | output | 1 | Card chip-select, active low |
| fast_rate | output | 1 | 0 selects the slow initialization clock, 1 the operating clock |
| done | output | 1 | One-cycle pulse on successful bring-up |
| err | output | 1 | Sticky failure flag |

## Verification
A wrong frame counter or byte mux shows up as a wrong `xfer_tx` value or a wrong `cs_n` level on the very next transfer. A response-selection fault appears only one attempt later, as an extra retry or a stage skipped too early, and so it shows in the byte stream within one frame plus one pause. A fault in the retry counter or the pause timer stays hidden until the budget runs out or a pause ends. That is the reason the bench compares every transfer and every cycle of `done`, `err` and `fast_rate` against a model built from the card's scripted replies.

// File: rtl/sdi_pkg.sv
`timescale 1ns/1ps
package sdi_pkg;
  localparam logic [7:0]  FILL_BYTE  = 8'hFF;
  localparam logic [7:0]  CHECK_BYTE = 8'h95;
  localparam logic [7:0]  OP_RESET   = 8'h40;
  localparam logic [7:0]  OP_LEAVE   = 8'h41;
  localparam logic [7:0]  OP_BLKLEN  = 8'h50;
  localparam logic [31:0] BLKLEN_ARG = 32'd512;
  localparam logic [7:0]  RESP_IDLE  = 8'h01;
  localparam logic [7:0]  RESP_READY = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RST,
    ST_RST_DLY,
    ST_LVE,
    ST_LVE_DLY,
    ST_BLEN
  } seq_state_t;
endpackage

// File: rtl/sdi_frame.sv
`timescale 1ns/1ps
module sdi_frame
  import sdi_pkg::*;
#(
  parameter int PRE_BYTES  = 10,
  parameter int POLL_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        pre_mode,
  input  logic [7:0]  cmd,
  input  logic [31:0] arg,
  output logic        xfer_req,
  output logic [7:0]  xfer_tx,
  input  logic        xfer_ack,
  input  logic [7:0]  xfer_rx,
  output logic        cs_n,
  output logic        fin,
  output logic [7:0]  resp
);
  localparam int HDR_BYTES = 6;
  localparam int CMD_BYTES = HDR_BYTES + POLL_BYTES;
  localparam int MAX_BYTES = (PRE_BYTES > CMD_BYTES) ? PRE_BYTES : CMD_BYTES;
  localparam int CW        = $clog2(MAX_BYTES + 1);

  logic          active_q, active_d;
  logic          pre_q, pre_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    resp_q, resp_d;
  logic [7:0]    cmd_q, cmd_d;
  logic [31:0]   arg_q, arg_d;
  logic          hs, last;

  always_comb begin
    hs       = active_q && xfer_ack;
    last     = pre_q ? (cnt_q == CW'(PRE_BYTES - 1)) : (cnt_q == CW'(CMD_BYTES - 1));
    active_d = active_q;
    pre_d    = pre_q;
    cnt_d    = cnt_q;
    resp_d   = resp_q;
    cmd_d    = cmd_q;
    arg_d    = arg_q;
    if (!active_q) begin
      if (go) begin
        active_d = 1'b1;
        pre_d    = pre_mode;
        cnt_d    = '0;
        resp_d   = FILL_BYTE;
        cmd_d    = cmd;
        arg_d    = arg;
      end
    end else if (hs) begin
      // keep the most recent non-fill byte of the poll window
      if (!pre_q && (cnt_q >= CW'(HDR_BYTES)) && (xfer_rx != FILL_BYTE)) resp_d = xfer_rx;
      if (last) active_d = 1'b0;
      else      cnt_d    = cnt_q + 1'b1;
    end
  end

  always_comb begin
    xfer_tx = FILL_BYTE;
    if (!pre_q) begin
      case (cnt_q)
        CW'(0):  xfer_tx = cmd_q;
        CW'(1):  xfer_tx = arg_q[31:24];
        CW'(2):  xfer_tx = arg_q[23:16];
        CW'(3):  xfer_tx = arg_q[15:8];
        CW'(4):  xfer_tx = arg_q[7:0];
        CW'(5):  xfer_tx = CHECK_BYTE;
        default: xfer_tx = FILL_BYTE;
      endcase
    end
  end

  assign xfer_req = active_q;
  assign cs_n     = !(active_q && !pre_q);
  assign fin      = hs && last;
  assign resp     = resp_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pre_q    <= 1'b0;
      cnt_q    <= '0;
      resp_q   <= FILL_BYTE;
      cmd_q    <= '0;
      arg_q    <= '0;
    end else begin
      active_q <= active_d;
      pre_q    <= pre_d;
      cnt_q    <= cnt_d;
      resp_q   <= resp_d;
      cmd_q    <= cmd_d;
      arg_q    <= arg_d;
    end
  end
endmodule

// File: rtl/sdi_delay.sv
`timescale 1ns/1ps
module sdi_delay #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int W = $clog2(CYCLES + 1);

  logic         run_q, run_d;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    expired = run_q && (cnt_q == '0);
    run_d   = run_q;
    cnt_d   = cnt_q;
    if (load) begin
      run_d = 1'b1;
      cnt_d = W'(CYCLES - 1);
    end else if (expired) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sdi_init_seq.sv
`timescale 1ns/1ps
module sdi_init_seq
  import sdi_pkg::*;
#(
  parameter int CYC_PER_MS = 25000,
  parameter int WAIT_MS    = 10,
  parameter int MAX_TRIES  = 100,
  parameter int PRE_BYTES  = 10,
  parameter int POLL_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       xfer_req,
  output logic [7:0] xfer_tx,
  input  logic       xfer_ack,
  input  logic [7:0] xfer_rx,
  output logic       cs_n,
  output logic       fast_rate,
  output logic       done,
  output logic       err
);
  localparam int DLY_CYCLES = CYC_PER_MS * WAIT_MS;
  localparam int TW         = $clog2(MAX_TRIES + 1);

  seq_state_t  state_q, state_d;
  logic [TW-1:0] tries_q, tries_d;
  logic        go_q, go_d;
  logic        pre_q, pre_d;
  logic [7:0]  cmd_q, cmd_d;
  logic [31:0] arg_q, arg_d;
  logic        inited_q, inited_d;
  logic        fast_q, fast_d;
  logic        done_q, done_d;
  logic        err_q, err_d;
  logic        dly_load, dly_exp;
  logic        fin;
  logic [7:0]  resp;
  logic        out_of_tries;

  sdi_frame #(.PRE_BYTES(PRE_BYTES), .POLL_BYTES(POLL_BYTES)) u_frame (
    .clk(clk), .rst_n(rst_n), .go(go_q), .pre_mode(pre_q), .cmd(cmd_q), .arg(arg_q),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .cs_n(cs_n), .fin(fin), .resp(resp)
  );

  sdi_delay #(.CYCLES(DLY_CYCLES)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .expired(dly_exp)
  );

  always_comb begin
    state_d      = state_q;
    tries_d      = tries_q;
    go_d         = 1'b0;
    pre_d        = 1'b0;
    cmd_d        = cmd_q;
    arg_d        = arg_q;
    inited_d     = inited_q;
    fast_d       = fast_q;
    done_d       = 1'b0;
    err_d        = err_q;
    dly_load     = 1'b0;
    out_of_tries = (tries_q == TW'(MAX_TRIES));
    case (state_q)
      ST_IDLE: if (start) begin
        if (inited_q) begin
          done_d = 1'b1;
        end else begin
          err_d   = 1'b0;
          fast_d  = 1'b0;
          go_d    = 1'b1;
          pre_d   = 1'b1;
          state_d = ST_PRE;
        end
      end
      ST_PRE: if (fin) begin
        go_d    = 1'b1;
        cmd_d   = OP_RESET;
        arg_d   = '0;
        tries_d = TW'(1);
        state_d = ST_RST;
      end
      ST_RST: if (fin) begin
        if (resp == RESP_IDLE) begin
          go_d    = 1'b1;
          cmd_d   = OP_LEAVE;
          tries_d = TW'(1);
          state_d = ST_LVE;
        end else if (out_of_tries) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          dly_load = 1'b1;
          state_d  = ST_RST_DLY;
        end
      end
      ST_RST_DLY: if (dly_exp) begin
        go_d    = 1'b1;
        tries_d = tries_q + 1'b1;
        state_d = ST_RST;
      end
      ST_LVE: if (fin) begin
        if (resp == RESP_READY) begin
          fast_d  = 1'b1;
          go_d    = 1'b1;
          cmd_d   = OP_BLKLEN;
          arg_d   = BLKLEN_ARG;
          state_d = ST_BLEN;
        end else if (out_of_tries) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          dly_load = 1'b1;
          state_d  = ST_LVE_DLY;
        end
      end
      ST_LVE_DLY: if (dly_exp) begin
        go_d    = 1'b1;
        tries_d = tries_q + 1'b1;
        state_d = ST_LVE;
      end
      ST_BLEN: if (fin) begin
        inited_d = 1'b1;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tries_q  <= '0;
      go_q     <= 1'b0;
      pre_q    <= 1'b0;
      cmd_q    <= '0;
      arg_q    <= '0;
      inited_q <= 1'b0;
      fast_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      tries_q  <= tries_d;
      go_q     <= go_d;
      pre_q    <= pre_d;
      cmd_q    <= cmd_d;
      arg_q    <= arg_d;
      inited_q <= inited_d;
      fast_q   <= fast_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign fast_rate = fast_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/sdi_init_seq_chk.sv
`timescale 1ns/1ps
module sdi_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       xfer_req,
  input logic [7:0] xfer_tx,
  input logic       xfer_ack,
  input logic       cs_n,
  input logic       fast_rate,
  input logic       done,
  input logic       err
);
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

  p_cs_in_transfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> xfer_req);

  p_rate_switch_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_rate) |-> (cs_n && !xfer_req));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);
endmodule

bind sdi_init_seq sdi_init_seq_chk u_chk (.*);

// File: tb/sdi_init_seq_test.sv
`timescale 1ns/1ps
module sdi_init_seq_test;
  localparam int CPM   = 3;
  localparam int WMS   = 10;
  localparam int TRIES = 100;
  localparam int DLY   = CPM * WMS;

  logic       clk, rst_n, start;
  logic       xfer_req, xfer_ack, cs_n, fast_rate, done, err;
  logic [7:0] xfer_tx, xfer_rx;

  sdi_init_seq #(.CYC_PER_MS(CPM), .WAIT_MS(WMS), .MAX_TRIES(TRIES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .cs_n(cs_n), .fast_rate(fast_rate),
    .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0, failed = 0;
  int scen = 0;
  logic [7:0] q_tx[$], q_rx[$];
  bit         q_cs[$];
  int         q_kind[$];
  bit   busy = 0, m_inited = 0, exp_done = 0, exp_err = 0, exp_fast = 0;
  bit   gap_on = 0;
  int   gap = 0, wcnt = 0, xfers = 0, dones = 0, cyc = 0;
  logic [7:0] tx_first = 8'h00;
  logic st_seen;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // scripted card replies per scenario, command, attempt and poll position
  function automatic logic [7:0] card_rx(int sc, logic [7:0] c, int att, int pos);
    logic [7:0] r = 8'hFF;
    case (sc)
      0: begin
        if (c == 8'h40 && att == 2) begin
          if (pos == 1) r = 8'h05;
          if (pos == 5) r = 8'h01;
        end else if (c == 8'h41 && att == 1) begin
          if (pos == 3) r = 8'h00;   // R3: a later non-fill byte overrides this
          if (pos == 6) r = 8'h01;
        end else if (c == 8'h41) begin
          if (pos == 0) r = 8'h01;
          if (pos == 7) r = 8'h00;
        end else if (c == 8'h50 && pos == 2) r = 8'h00;
      end
      2: begin
        if (c == 8'h40 && pos == 0) r = 8'h01;
        else if (c == 8'h41 && pos == 4) r = 8'h01;
      end
      3: begin
        if (c == 8'h40 && pos == 7) r = 8'h01;
        else if (c == 8'h41 && pos == 1) r = 8'h00;
        else if (c == 8'h50 && pos == 0) r = 8'h00;
      end
      default: r = 8'hFF;
    endcase
    return r;
  endfunction

  task automatic push(logic [7:0] t, bit c, logic [7:0] r);
    q_tx.push_back(t); q_cs.push_back(c); q_rx.push_back(r); q_kind.push_back(0);
  endtask

  task automatic send(logic [7:0] c, logic [31:0] a, int att, output logic [7:0] resp);
    logic [7:0] r;
    push(c, 0, 8'hFF);
    for (int i = 3; i >= 0; i--) push(a[8*i +: 8], 0, 8'hFF);
    push(8'h95, 0, 8'hFF);
    resp = 8'hFF;
    for (int p = 0; p < 8; p++) begin
      r = card_rx(scen, c, att, p);
      push(8'hFF, 0, r);
      if (r != 8'hFF) resp = r;  // R3
    end
  endtask

  // kinds: 1 retry pause follows, 2 rate switch, 3 success, 4 failure
  task automatic build();
    logic [7:0] resp;
    bit ok;
    for (int i = 0; i < 10; i++) push(8'hFF, 1, 8'hFF);
    ok = 0;
    for (int a = 1; a <= TRIES; a++) begin
      send(8'h40, 32'd0, a, resp);
      if (resp == 8'h01) begin ok = 1; break; end
      q_kind[q_kind.size()-1] = (a == TRIES) ? 4 : 1;
    end
    if (!ok) return;
    ok = 0;
    for (int a = 1; a <= TRIES; a++) begin
      send(8'h41, 32'd0, a, resp);
      if (resp == 8'h00) begin ok = 1; q_kind[q_kind.size()-1] = 2; break; end
      q_kind[q_kind.size()-1] = (a == TRIES) ? 4 : 1;
    end
    if (!ok) return;
    send(8'h50, 32'd512, 1, resp);
    q_kind[q_kind.size()-1] = 3;
  endtask

  always @(posedge clk) st_seen <= start;

  // card side, reference model and per-cycle comparison
  always @(negedge clk) begin
    bit was_ack;
    int k;
    if (rst_n) begin
      exp_done = 0;
      was_ack  = xfer_ack;
      if (xfer_ack) begin
        xfer_ack = 0;
        wcnt = 0;
        xfers++;
        k = q_kind.pop_front();
        void'(q_tx.pop_front()); void'(q_cs.pop_front()); void'(q_rx.pop_front());
        case (k)
          1: begin gap_on = 1; gap = 0; end
          2: exp_fast = 1;
          3: begin exp_done = 1; m_inited = 1; busy = 0; end
          4: begin exp_err = 1; busy = 0; end
          default: ;
        endcase
      end
      if (st_seen && !busy) begin
        if (m_inited) exp_done = 1;
        else begin
          exp_err = 0; exp_fast = 0; busy = 1;
          build();
        end
      end
      if (done) dones++;
      chk(done == exp_done, "R8/R9", "done", done, exp_done);
      chk(err == exp_err, "R4/R10", "err", err, exp_err);
      chk(fast_rate == exp_fast, "R7", "fast_rate", fast_rate, exp_fast);
      if (!was_ack && xfer_req) begin
        if (q_tx.size() == 0) begin
          chk(0, "R9", "unexpected transfer", xfer_tx, 0);
        end else begin
          if (gap_on) begin
            chk(gap >= DLY && gap <= DLY + 4, "R5", "retry pause", gap, DLY);
            gap_on = 0;
          end
          wcnt++;
          if (wcnt == 1) tx_first = xfer_tx;
          if (wcnt == 2) begin
            chk(xfer_tx == tx_first, "R11", "tx held", xfer_tx, tx_first);
            chk(xfer_tx == q_tx[0], "R1/R2/R4/R6/R8", "tx byte", xfer_tx, q_tx[0]);
            chk(cs_n == q_cs[0], "R1/R2", "cs_n", cs_n, q_cs[0]);
            xfer_rx  = q_rx[0];
            xfer_ack = 1;
          end
        end
      end else if (gap_on && !xfer_req) gap++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(0, "R4", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; xfer_ack = 0; xfer_rx = 8'hFF; start = 0;
    q_tx.delete(); q_rx.delete(); q_cs.delete(); q_kind.delete();
    busy = 0; m_inited = 0; exp_done = 0; exp_err = 0; exp_fast = 0; gap_on = 0; wcnt = 0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 start = 1;
    @(negedge clk); #1 start = 0;
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #1; end while (busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int x0, d0;
    rst_n = 0; start = 0; xfer_ack = 0; xfer_rx = 8'hFF;
    do_reset();
    @(negedge clk); #1;
    chk(cs_n == 1, "R1", "reset cs_n", cs_n, 1);
    chk(xfer_req == 0, "R11", "reset xfer_req", xfer_req, 0);
    chk(done == 0 && err == 0, "R8", "reset done/err", {done, err}, 0);
    chk(fast_rate == 0, "R7", "reset fast_rate", fast_rate, 0);

    // scenario 0: retries in both stages, R3 last-non-fill selection
    scen = 0; d0 = dones;
    pulse_start(); wait_idle();
    chk(dones == d0 + 1, "R8", "done pulses", dones - d0, 1);
    chk(q_tx.size() == 0, "R6", "stream complete", q_tx.size(), 0);
    chk(fast_rate == 1, "R7", "rate after success", fast_rate, 1);

    // R9: already initialized, no bus traffic
    x0 = xfers; d0 = dones;
    pulse_start(); repeat (20) @(negedge clk);
    chk(xfers == x0, "R9", "transfers on repeat start", xfers - x0, 0);
    chk(dones == d0 + 1, "R9", "done on repeat start", dones - d0, 1);

    // scenario 1: card never answers, reset stage exhausts its budget
    do_reset(); scen = 1;
    pulse_start(); wait_idle();
    chk(err == 1, "R4", "err after reset budget", err, 1);
    x0 = xfers; repeat (30) @(negedge clk);
    chk(xfers == x0 && err == 1, "R10", "quiet and sticky", xfers - x0, 0);

    // scenario 2: idle-exit stage exhausts its budget, started from error
    scen = 2; d0 = dones;
    pulse_start(); wait_idle();
    chk(err == 1, "R6", "err after idle-exit budget", err, 1);
    chk(dones == d0, "R6", "no done on failure", dones - d0, 0);

    // scenario 3: success from error, with a start while busy ignored
    scen = 3; d0 = dones;
    pulse_start(); repeat (25) @(negedge clk);
    pulse_start(); wait_idle();
    chk(err == 0 && dones == d0 + 1, "R10", "busy start ignored", dones - d0, 1);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule